// File: doc/BRIEF.md
# Multipath Combining Matched Filter with Default-Tap Fallback

This block is a sixteen-tap complex FIR filter for a spread-spectrum receiver. It sums delayed copies of the incoming I/Q chip stream, each weighted by a complex coefficient, so that energy arriving over several propagation paths adds up the way a RAKE combiner gathers it. An external channel estimator or host writes the estimated taps one at a time into a staging bank. Writing to the staging bank does not change the filter.

The filter only changes coefficients when the load strobe is pulsed. At that edge the block compares two quality metrics against programmable limits. One is a signal-to-noise figure and the other is a continuous-wave interference figure. If either metric says the estimate cannot be trusted, a fixed built-in tap set is made active instead. This set shapes only the known transmit and receive path distortion. Otherwise the staged estimate is made active. The whole bank is replaced in a single edge, and a status pin reports which set is in use.

Both sample streams use valid/ready handshakes. A sample is accepted on any rising edge where `in_valid` and `in_ready` are both high. A result is taken on any rising edge where `out_valid` and `out_ready` are both high. While a result waits for a consumer that is not ready, the whole pipeline freezes: the output holds steady and `in_ready` stays low. `in_ready` depends only on `out_valid` and `out_ready`, never on `in_valid`. The coefficient port, metrics, thresholds, load strobe and status are plain control pins.

Top module: `chan_mf`

## Requirements
- R1: Each output is the sum over taps j = 0..15 of h[j]·x[n−j]. Here x[n] is the n-th accepted sample (I real, Q imaginary), and the history is zero after reset. The I output is Σ(hr·xi − hi·xq) and the Q output is Σ(hr·xq + hi·xi). Coefficients are 8-bit signed in Q1.6 format, so 64 means unity.
- R2: The complex sum is rounded by adding 32 and then shifting arithmetically right by 6 (halves round toward +∞). It is then saturated to the signed 12-bit range [−2048, 2047].
- R3: Every accepted sample yields exactly one output, in order. With `out_ready` high, a sample accepted at rising edge k makes `out_valid` rise after edge k+2 and not before.
- R4: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_i` and `out_q` hold their values across the next edge. No sample is lost or repeated.
- R5: A write with `coef_we` high stores (`coef_re`, `coef_im`) into staging slot `coef_addr`. Slot 0 weights the newest sample. Staged values have no effect on outputs until a load.
- R6: A load with `snr_lvl` < `snr_min` (unsigned) activates the default set and sets `fallback_on` to 1.
- R7: A load with `cwi_lvl` > `cwi_max` (unsigned) activates the default set and sets `fallback_on` to 1.
- R8: A load with `snr_lvl` ≥ `snr_min` and `cwi_lvl` ≤ `cwi_max` (equality counts as acceptable) copies the staging bank into the active bank and clears `fallback_on`.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, `fallback_on` is 1, the default set is active and all staging slots are zero.
- R10: The default set has real taps 64, −8 and +4 at slots 0, 1 and 2. All its other taps and all its imaginary parts are zero.
- R11: A sample uses the active bank as it stands after the edge that accepts it, provided the next edge is not stalled. A load on that same edge therefore applies to the sample, and a load one edge later does not. A load and a staging write on the same edge copy the staging contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Filter can accept a sample |
| in_i | input | 10 | Input sample, in-phase, signed |
| in_q | input | 10 | Input sample, quadrature, signed |
| out_valid | output | 1 | Filtered sample valid |
| out_ready | input | 1 | Consumer accepts the filtered sample |
| out_i | output | 12 | Filtered in-phase, signed |
| out_q | output | 12 | Filtered quadrature, signed |
| coef_we | input | 1 | Staging bank write enable |
| coef_addr | input | 4 | Staging slot index |
| coef_re | input | 8 | Coefficient real part, signed Q1.6 |
| coef_im | input | 8 | Coefficient imaginary part, signed Q1.6 |
| bank_load | input | 1 | Make a new coefficient set active |
| snr_lvl | input | 8 | Signal-to-noise metric |
| snr_min | input | 8 | Lowest acceptable signal-to-noise metric |
| cwi_lvl | input | 8 | CW-interference metric |
| cwi_max | input | 8 | Highest acceptable CW-interference metric |
| fallback_on | output | 1 | 1 when the default set is active |

## Verification
A bank swap can land on the same edge as a sample entering the filter. A staging write can also land on the same edge as a bank swap. The bench drives a load on the accepting edge of one sample, and then a load one edge after another sample is accepted. It also issues a load together with a write to slot 0. The scoreboard model applies the swap before it forms each sample's expected result, and it copies staging before it applies the write. Any output mixing the wrong set, or a copy that picks up the new write, is reported as a mismatch against R11.

// File: rtl/chan_mf_pkg.sv
package chan_mf_pkg;

  localparam int COEF_W    = 8;
  localparam int COEF_FRAC = 6;

  typedef logic [COEF_W-1:0] coef_t;

  typedef struct packed {
    coef_t re;
    coef_t im;
  } ccoef_t;

  // Fixed shaping taps: unity main path with a mild pre/post correction
  // for the known converter and filter distortion.
  function automatic ccoef_t dflt_coef(input int unsigned idx);
    ccoef_t c;
    c.im = '0;
    case (idx)
      0:       c.re = COEF_W'(64);
      1:       c.re = COEF_W'(-8);
      2:       c.re = COEF_W'(4);
      default: c.re = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/chan_mf_coef_bank.sv
module chan_mf_coef_bank
  import chan_mf_pkg::*;
#(
  parameter int NTAPS = 16,
  parameter int MET_W = 8,
  localparam int AW = $clog2(NTAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  coef_t                  wr_re,
  input  coef_t                  wr_im,
  input  logic                   load,
  input  logic [MET_W-1:0]       snr_lvl,
  input  logic [MET_W-1:0]       snr_min,
  input  logic [MET_W-1:0]       cwi_lvl,
  input  logic [MET_W-1:0]       cwi_max,
  output ccoef_t [NTAPS-1:0]     act_bank,
  output logic                   dflt_on
);

  ccoef_t [NTAPS-1:0] stg_bank;
  ccoef_t [NTAPS-1:0] dflt_bank;
  logic               snr_low;
  logic               cwi_high;
  logic               pick_dflt;

  assign snr_low   = snr_lvl < snr_min;
  assign cwi_high  = cwi_lvl > cwi_max;
  assign pick_dflt = snr_low | cwi_high;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    localparam ccoef_t DF = dflt_coef(t);
    assign dflt_bank[t] = DF;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_bank[t] <= '0;
      end else if (wr_en && wr_addr == AW'(t)) begin
        stg_bank[t].re <= wr_re;
        stg_bank[t].im <= wr_im;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_bank[t] <= DF;
      end else if (load) begin
        act_bank[t] <= pick_dflt ? DF : stg_bank[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dflt_on <= 1'b1;
    else if (load) dflt_on <= pick_dflt;
  end

  // R5: nothing but a load alters the active set
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_bank) && $stable(dflt_on));

  // R6: low SNR metric at load forces the default set
  p_snr_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load && (snr_lvl < snr_min) |=> dflt_on && act_bank == dflt_bank);

  // R7: excess interference at load forces the default set
  p_cwi_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load && (cwi_lvl > cwi_max) |=> dflt_on && act_bank == dflt_bank);

  // R8 and R11: good metrics copy staging as it was before the edge
  p_est_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load && (snr_lvl >= snr_min) && (cwi_lvl <= cwi_max)
      |=> !dflt_on && act_bank == $past(stg_bank));

endmodule

// File: rtl/chan_mf_tap_line.sv
module chan_mf_tap_line #(
  parameter int NTAPS = 16,
  parameter int IN_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift,
  input  logic [IN_W-1:0]             din_i,
  input  logic [IN_W-1:0]             din_q,
  output logic [NTAPS-1:0][IN_W-1:0]  tap_i,
  output logic [NTAPS-1:0][IN_W-1:0]  tap_q
);

  for (genvar t = 0; t < NTAPS; t++) begin : g_stage
    if (t == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tap_i[0] <= '0;
          tap_q[0] <= '0;
        end else if (shift) begin
          tap_i[0] <= din_i;
          tap_q[0] <= din_q;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tap_i[t] <= '0;
          tap_q[t] <= '0;
        end else if (shift) begin
          tap_i[t] <= tap_i[t-1];
          tap_q[t] <= tap_q[t-1];
        end
      end
    end
  end

  // R1: an accepted sample lands at the head of the history
  p_head_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> tap_i[0] == $past(din_i) && tap_q[0] == $past(din_q));

  // R4: a frozen pipeline keeps its history
  p_line_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(tap_i) && $stable(tap_q));

endmodule

// File: rtl/chan_mf_cmac.sv
module chan_mf_cmac
  import chan_mf_pkg::*;
#(
  parameter int NTAPS = 16,
  parameter int IN_W  = 10,
  parameter int OUT_W = 12,
  localparam int PW    = IN_W + COEF_W + 1,
  localparam int ACC_W = PW + $clog2(NTAPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        s0_valid,
  input  logic [NTAPS-1:0][IN_W-1:0]  tap_i,
  input  logic [NTAPS-1:0][IN_W-1:0]  tap_q,
  input  ccoef_t [NTAPS-1:0]          bank,
  output logic                        out_valid,
  output logic [OUT_W-1:0]            out_i,
  output logic [OUT_W-1:0]            out_q
);

  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = -ACC_W'(64'sd1 <<< (OUT_W-1));
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(64'sd1 <<< (COEF_FRAC-1));

  logic signed [PW-1:0] pr_re [NTAPS];
  logic signed [PW-1:0] pr_im [NTAPS];
  logic                 s1_valid;

  // Stage 1: one complex multiply per tap, registered
  for (genvar t = 0; t < NTAPS; t++) begin : g_mul
    logic signed [PW-1:0] xi, xq, cr, ci;
    assign xi = {{(PW-IN_W){tap_i[t][IN_W-1]}}, tap_i[t]};
    assign xq = {{(PW-IN_W){tap_q[t][IN_W-1]}}, tap_q[t]};
    assign cr = {{(PW-COEF_W){bank[t].re[COEF_W-1]}}, bank[t].re};
    assign ci = {{(PW-COEF_W){bank[t].im[COEF_W-1]}}, bank[t].im};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pr_re[t] <= '0;
        pr_im[t] <= '0;
      end else if (adv) begin
        pr_re[t] <= xi * cr - xq * ci;
        pr_im[t] <= xq * cr + xi * ci;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   s1_valid <= 1'b0;
    else if (adv) s1_valid <= s0_valid;
  end

  // Stage 2: adder tree, rounding and clamp
  logic signed [ACC_W-1:0] sum_re, sum_im;
  logic signed [ACC_W-1:0] rnd_re, rnd_im;

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int t = 0; t < NTAPS; t++) begin
      sum_re = sum_re + {{(ACC_W-PW){pr_re[t][PW-1]}}, pr_re[t]};
      sum_im = sum_im + {{(ACC_W-PW){pr_im[t][PW-1]}}, pr_im[t]};
    end
    rnd_re = (sum_re + HALF_LSB) >>> COEF_FRAC;
    rnd_im = (sum_im + HALF_LSB) >>> COEF_FRAC;
  end

  function automatic logic [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_i     <= clamp(rnd_re);
      out_q     <= clamp(rnd_im);
    end
  end

  // R4: a stalled result stays put
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !adv |=> out_valid && $stable(out_i) && $stable(out_q));

  // R3: a product stage that advances always yields a result next
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s1_valid |=> out_valid);

endmodule

// File: rtl/chan_mf.sv
module chan_mf
  import chan_mf_pkg::*;
#(
  parameter int NTAPS = 16,
  parameter int IN_W  = 10,
  parameter int OUT_W = 12,
  parameter int MET_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [IN_W-1:0]           in_i,
  input  logic [IN_W-1:0]           in_q,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OUT_W-1:0]          out_i,
  output logic [OUT_W-1:0]          out_q,
  input  logic                      coef_we,
  input  logic [$clog2(NTAPS)-1:0]  coef_addr,
  input  logic [COEF_W-1:0]         coef_re,
  input  logic [COEF_W-1:0]         coef_im,
  input  logic                      bank_load,
  input  logic [MET_W-1:0]          snr_lvl,
  input  logic [MET_W-1:0]          snr_min,
  input  logic [MET_W-1:0]          cwi_lvl,
  input  logic [MET_W-1:0]          cwi_max,
  output logic                      fallback_on
);

  logic                       adv;
  logic                       s0_valid;
  logic [NTAPS-1:0][IN_W-1:0] tap_i, tap_q;
  ccoef_t [NTAPS-1:0]         act_bank;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n)   s0_valid <= 1'b0;
    else if (adv) s0_valid <= in_valid;
  end

  chan_mf_coef_bank #(.NTAPS(NTAPS), .MET_W(MET_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (coef_we),
    .wr_addr  (coef_addr),
    .wr_re    (coef_re),
    .wr_im    (coef_im),
    .load     (bank_load),
    .snr_lvl  (snr_lvl),
    .snr_min  (snr_min),
    .cwi_lvl  (cwi_lvl),
    .cwi_max  (cwi_max),
    .act_bank (act_bank),
    .dflt_on  (fallback_on)
  );

  chan_mf_tap_line #(.NTAPS(NTAPS), .IN_W(IN_W)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (in_valid && adv),
    .din_i (in_i),
    .din_q (in_q),
    .tap_i (tap_i),
    .tap_q (tap_q)
  );

  chan_mf_cmac #(.NTAPS(NTAPS), .IN_W(IN_W), .OUT_W(OUT_W)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .s0_valid  (s0_valid),
    .tap_i     (tap_i),
    .tap_q     (tap_q),
    .bank      (act_bank),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  // R4: a waiting result blocks new input
  p_no_accept_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3: a sample taken while the path runs is in flight on the next edge
  p_accept_tracked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s0_valid);

endmodule

// File: tb/chan_mf_tb.sv
`timescale 1ns/1ps
module chan_mf_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0, out_ready = 1;
  logic       in_ready, out_valid, fallback_on;
  logic [9:0] in_i = '0, in_q = '0;
  logic [11:0] out_i, out_q;
  logic       coef_we = 0, bank_load = 0;
  logic [3:0] coef_addr = '0;
  logic [7:0] coef_re = '0, coef_im = '0;
  logic [7:0] snr_lvl = 8'd50, snr_min = 8'd50, cwi_lvl = 8'd20, cwi_max = 8'd20;

  always #2 clk = ~clk;

  chan_mf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_re(coef_re), .coef_im(coef_im), .bank_load(bank_load),
    .snr_lvl(snr_lvl), .snr_min(snr_min), .cwi_lvl(cwi_lvl), .cwi_max(cwi_max),
    .fallback_on(fallback_on)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R9";
  int sm_re[16], sm_im[16], bk_re[16], bk_im[16], hi[16], hq[16];
  int exp_i[$], exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int dre(int t);
    return (t == 0) ? 64 : (t == 1) ? -8 : (t == 2) ? 4 : 0;
  endfunction

  function automatic int sat12(longint v);
    longint r = (v + 32) >>> 6;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  task automatic check(bit ok, string r, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic step(bit v, int xi, int xq, bit ld, bit wr, int wa, int wre, int wim, bit ordy);
    bit acc, fb;
    longint ai, aq;
    @(negedge clk);
    in_valid = v; in_i = xi[9:0]; in_q = xq[9:0];
    bank_load = ld; coef_we = wr; coef_addr = wa[3:0];
    coef_re = wre[7:0]; coef_im = wim[7:0]; out_ready = ordy;
    #1 acc = v && in_ready;
    @(posedge clk);
    if (ld) begin
      fb = (snr_lvl < snr_min) || (cwi_lvl > cwi_max);
      for (int t = 0; t < 16; t++) begin
        bk_re[t] = fb ? dre(t) : sm_re[t];
        bk_im[t] = fb ? 0 : sm_im[t];
      end
    end
    if (wr) begin sm_re[wa] = wre; sm_im[wa] = wim; end
    if (acc) begin
      for (int t = 15; t > 0; t--) begin hi[t] = hi[t-1]; hq[t] = hq[t-1]; end
      hi[0] = xi; hq[0] = xq;
      ai = 0; aq = 0;
      for (int t = 0; t < 16; t++) begin
        ai += longint'(bk_re[t]) * hi[t] - longint'(bk_im[t]) * hq[t];
        aq += longint'(bk_re[t]) * hq[t] + longint'(bk_im[t]) * hi[t];
      end
      exp_i.push_back(sat12(ai));
      exp_q.push_back(sat12(aq));
    end
    #1 in_valid = 0; bank_load = 0; coef_we = 0;
  endtask

  task automatic send(int xi, int xq); step(1, xi, xq, 0, 0, 0, 0, 0, 1); endtask
  task automatic idle(int n); repeat (n) step(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic wcoef(int a, int re, int im); step(0, 0, 0, 0, 1, a, re, im, 1); endtask

  task automatic load_chk(bit exp_fb, string r);
    step(0, 0, 0, 1, 0, 0, 0, 0, 1);
    @(negedge clk); #1;
    check(fallback_on == exp_fb, r, "fallback_on after load", fallback_on, exp_fb);
  endtask

  function automatic int rnd10();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[9:0]));
  endfunction

  // Scoreboard monitor and stall checker
  bit prev_hold = 0;
  logic [11:0] prev_i, prev_q;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (prev_hold) begin
        check(out_valid && out_i == prev_i && out_q == prev_q, "R4",
              "output held under stall", out_i, prev_i);
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R4", "in_ready low under stall", in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_i.size() == 0) begin
          check(0, "R3", "unexpected output count", 1, 0);
        end else begin
          int ei, eq;
          ei = exp_i.pop_front(); eq = exp_q.pop_front();
          check($signed(out_i) == ei, req, "out_i", $signed(out_i), ei);
          check($signed(out_q) == eq, req, "out_q", $signed(out_q), eq);
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_i = out_i; prev_q = out_q;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 16; t++) begin
      sm_re[t] = 0; sm_im[t] = 0; bk_re[t] = dre(t); bk_im[t] = 0; hi[t] = 0; hq[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R9: reset state
    check(out_valid == 0, "R9", "out_valid", out_valid, 0);
    check(in_ready == 1, "R9", "in_ready", in_ready, 1);
    check(fallback_on == 1, "R9", "fallback_on", fallback_on, 1);

    // R3: latency of a lone sample
    req = "R3";
    send(100, -40);
    @(negedge clk); #1; check(out_valid == 0, "R3", "valid after k", out_valid, 0);
    @(negedge clk); #1; check(out_valid == 0, "R3", "valid after k+1", out_valid, 0);
    @(negedge clk); #1; check(out_valid == 1, "R3", "valid after k+2", out_valid, 1);
    idle(2);

    // R10: default set impulse response
    req = "R10";
    send(200, 0);
    for (int n = 0; n < 17; n++) send(0, 0);
    idle(4);

    // R5: staged taps do not act before a load
    req = "R5";
    for (int t = 0; t < 16; t++) wcoef(t, 10 + 3 * t, 5 - t);
    for (int n = 0; n < 20; n++) send(rnd10(), rnd10());
    idle(4);
    check(fallback_on == 1, "R5", "fallback_on without load", fallback_on, 1);

    // R8: metrics exactly at their limits count as acceptable
    load_chk(0, "R8");
    req = "R1";
    for (int n = 0; n < 40; n++) send(rnd10(), rnd10());
    idle(4);

    // R6: weak SNR metric
    snr_lvl = 8'd49;
    load_chk(1, "R6");
    req = "R6";
    for (int n = 0; n < 20; n++) send(rnd10(), rnd10());
    idle(4);
    snr_lvl = 8'd50;
    load_chk(0, "R8");

    // R7: interference metric over its limit
    cwi_lvl = 8'd21;
    load_chk(1, "R7");
    req = "R7";
    for (int n = 0; n < 20; n++) send(rnd10(), rnd10());
    idle(4);
    cwi_lvl = 8'd20;

    // R2: rounding with a 1/64 tap, then saturation
    req = "R2";
    for (int t = 0; t < 16; t++) wcoef(t, (t == 0) ? 1 : 0, 0);
    load_chk(0, "R8");
    send(32, -32); send(31, -33); send(96, 95); send(-96, 0);
    for (int t = 0; t < 16; t++) wcoef(t, 127, 0);
    load_chk(0, "R8");
    for (int n = 0; n < 16; n++) send(511, -512);
    for (int n = 0; n < 16; n++) send(-512, 511);
    idle(4);

    // R4: random back-pressure on a continuous stream
    req = "R4";
    for (int t = 0; t < 16; t++) wcoef(t, rnd10() % 100, rnd10() % 100);
    load_chk(0, "R8");
    for (int n = 0; n < 80; n++) step(1, rnd10(), rnd10(), 0, 0, 0, 0, 0, lfsr[3] | lfsr[7]);
    idle(6);

    // R11: load on the accepting edge vs one edge later; load with write
    req = "R11";
    for (int t = 0; t < 16; t++) wcoef(t, 20 - 2 * t, t - 7);
    for (int n = 0; n < 6; n++) send(rnd10(), rnd10());
    step(1, 300, -200, 1, 0, 0, 0, 0, 1);
    send(-150, 250);
    for (int t = 0; t < 16; t++) wcoef(t, 5 + t, -3);
    send(222, 111);
    step(1, -99, 77, 1, 0, 0, 0, 0, 1);
    send(10, 20);
    step(0, 0, 0, 1, 1, 0, -60, 60, 1);
    for (int n = 0; n < 18; n++) send(rnd10(), rnd10());
    idle(6);

    check(exp_i.size() == 0, "R3", "outstanding expected items", exp_i.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule